// File: doc/BRIEF.md
# Debug Mode Entry and Exit Controller

This block keeps a hart's debug control and status word and runs the two sequences that move the hart in and out of debug mode. While the hart runs normally, it watches four sources that can stop it: an external halt request, a group halt request, a sticky halt bit inside the status word, and a breakpoint trap that software has chosen to route to the debugger. When one of them wins, the block saves the current pc and privilege, forces machine privilege and sends the hart to a fixed debug ROM entry address. When a debug-return strobe arrives in debug mode, it sends the hart back to the saved pc at the saved privilege, and it arms single-step if the step bit is set.

The status word can be read and written only in debug mode. Any read, write or return attempt made outside debug mode raises an illegal-instruction indication and has no effect. Some fields are constant, and the cause field is written only by hardware on entry. A breakpoint that is not routed to the debugger is flagged on a separate output so that the trap logic can take it as a normal trap.

Top module: `dbg_ctl`

## Requirements
- R1: A CSR read or write while `dbg_mode_o` is 0 raises `illegal_o` in the same cycle and leaves every field of the status word unchanged.
- R2: A read returns the packed word with version [31:28] = 1, stop-cycle (bit 10) = 0, stop-time (bit 9) = 0, bits [27:16], [11] and [5:4] = 0, ebreak-M bit 15, ebreak-H bit 14, ebreak-S bit 13, ebreak-U bit 12, cause [8:6], halt bit 3, step bit 2 and privilege [1:0] (U = 0, S = 1, M = 3).
- R3: A write in debug mode updates only privilege, step, halt and the four ebreak bits. Cause, version and the stop bits ignore the written data.
- R4: On the clock edge that samples a winning entry condition, `dbg_mode_o` becomes 1 and `redirect_o` pulses for one cycle with `next_pc_o` = ROM entry and `next_priv_o` = 3. `dpc_o` takes the current pc, and the privilege field takes the current privilege.
- R5: A breakpoint trap outside debug mode enters with cause 1 when (priv M and ebreak-M), (priv S and ebreak-S) or (priv U and ebreak-U). Otherwise it raises `bkpt_normal_o` in the same cycle and does not enter.
- R6: Entry cause priority: external halt (cause 3) over group halt (cause 6) over the halt bit (cause 3) over breakpoint (cause 1). A breakpoint that loses raises no `bkpt_normal_o`.
- R7: A debug return in debug mode clears `dbg_mode_o` and pulses `redirect_o` on the next edge with `next_pc_o` = `dpc_o` and `next_priv_o` = privilege field. `step_arm_o` then equals the step bit.
- R8: A debug return outside debug mode raises `illegal_o` and causes no redirect.
- R9: During reset the halt bit loads `halt_on_reset_i`, and all other fields and `dbg_mode_o` clear. A set halt bit makes the hart enter with cause 3 on the first edge after reset.
- R10: `step_arm_o` is cleared on every debug entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| halt_on_reset_i | input | 1 | Value given to the halt bit during reset |
| cur_pc_i | input | PC_W | Current pc of the hart |
| cur_priv_i | input | 2 | Current privilege level |
| ext_halt_i | input | 1 | External halt request |
| grp_halt_i | input | 1 | Group halt request |
| bkpt_trap_i | input | 1 | Breakpoint trap raised by the current instruction |
| csr_rd_i | input | 1 | Read of the status word |
| csr_wr_i | input | 1 | Write of the status word |
| csr_wdata_i | input | 32 | Write data |
| dret_i | input | 1 | Debug-return strobe |
| dbg_mode_o | output | 1 | Hart is in debug mode |
| redirect_o | output | 1 | One-cycle pulse: take next_pc_o and next_priv_o |
| next_pc_o | output | PC_W | Redirect target pc |
| next_priv_o | output | 2 | Redirect target privilege |
| dpc_o | output | PC_W | Saved debug pc |
| step_arm_o | output | 1 | Single-step armed after return |
| illegal_o | output | 1 | Illegal-instruction indication for CSR or return access |
| bkpt_normal_o | output | 1 | Breakpoint to be taken as a normal trap |
| csr_rdata_o | output | 32 | Packed status word |

## Verification
The breakpoint routing is swept over all four privilege codes and all sixteen ebreak-bit patterns. This separates a correct per-privilege match from one that ignores the privilege, uses the wrong bit, or lets the reserved level 2 through. The four entry sources are swept over all fifteen non-empty combinations, and the recorded cause shows the priority order, since group halt (6) is distinct from the two sources that report cause 3. Writes of all-ones and all-zeros patterns, with junk in the cause and version bits, tell writable fields apart from fixed ones. Accesses made outside debug mode show that such attempts are ignored.

// File: rtl/dbg_pkg.sv
package dbg_pkg;

    typedef enum logic [1:0] {
        PRIV_U   = 2'd0,
        PRIV_S   = 2'd1,
        PRIV_RSV = 2'd2,
        PRIV_M   = 2'd3
    } priv_e;

    typedef enum logic [2:0] {
        CAUSE_NONE  = 3'd0,
        CAUSE_SWBP  = 3'd1,
        CAUSE_HALT  = 3'd3,
        CAUSE_STEP  = 3'd4,
        CAUSE_GROUP = 3'd6
    } cause_e;

    typedef struct packed {
        logic   eb_m;
        logic   eb_h;
        logic   eb_s;
        logic   eb_u;
        logic   halt;
        logic   step;
        priv_e  prv;
        cause_e cause;
    } dstat_t;

    localparam logic [3:0] DBG_VERSION = 4'd1;
    localparam int         NUM_SRC     = 4;

    // Fixed-priority source order: index 0 wins.
    localparam int SRC_EXT  = 0;
    localparam int SRC_GRP  = 1;
    localparam int SRC_HBIT = 2;
    localparam int SRC_BKPT = 3;

    function automatic cause_e src_cause(input int idx);
        case (idx)
            SRC_EXT:  return CAUSE_HALT;
            SRC_GRP:  return CAUSE_GROUP;
            SRC_HBIT: return CAUSE_HALT;
            default:  return CAUSE_SWBP;
        endcase
    endfunction

    function automatic logic [31:0] pack_stat(input dstat_t s);
        logic [31:0] w;
        w        = '0;
        w[31:28] = DBG_VERSION;
        w[15]    = s.eb_m;
        w[14]    = s.eb_h;
        w[13]    = s.eb_s;
        w[12]    = s.eb_u;
        w[10]    = 1'b0;
        w[9]     = 1'b0;
        w[8:6]   = s.cause;
        w[3]     = s.halt;
        w[2]     = s.step;
        w[1:0]   = s.prv;
        return w;
    endfunction

    function automatic dstat_t merge_write(input dstat_t s, input logic [31:0] w);
        dstat_t n;
        n      = s;
        n.eb_m = w[15];
        n.eb_h = w[14];
        n.eb_s = w[13];
        n.eb_u = w[12];
        n.halt = w[3];
        n.step = w[2];
        n.prv  = priv_e'(w[1:0]);
        return n;
    endfunction

endpackage

// File: rtl/dbg_stat_reg.sv
module dbg_stat_reg
    import dbg_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        halt_on_reset_i,
    input  logic        wr_en_i,
    input  logic [31:0] wdata_i,
    input  logic        enter_i,
    input  cause_e      enter_cause_i,
    input  priv_e       enter_priv_i,
    output dstat_t      stat_o
);

    dstat_t stat_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stat_q      <= '0;
            stat_q.halt <= halt_on_reset_i;
        end else if (enter_i) begin
            stat_q.cause <= enter_cause_i;
            stat_q.prv   <= enter_priv_i;
        end else if (wr_en_i) begin
            stat_q <= merge_write(stat_q, wdata_i);
        end
    end

    assign stat_o = stat_q;

endmodule

// File: rtl/dbg_cause_arb.sv
module dbg_cause_arb
    import dbg_pkg::*;
(
    input  logic   dbg_mode_i,
    input  logic   ext_halt_i,
    input  logic   grp_halt_i,
    input  logic   halt_bit_i,
    input  logic   bkpt_trap_i,
    input  priv_e  cur_priv_i,
    input  logic   eb_m_i,
    input  logic   eb_s_i,
    input  logic   eb_u_i,
    output logic   enter_o,
    output cause_e cause_o,
    output logic   bkpt_normal_o
);

    logic                bkpt_route;
    logic [NUM_SRC-1:0]  req;

    always_comb begin
        case (cur_priv_i)
            PRIV_M:  bkpt_route = eb_m_i;
            PRIV_S:  bkpt_route = eb_s_i;
            PRIV_U:  bkpt_route = eb_u_i;
            default: bkpt_route = 1'b0;
        endcase
    end

    always_comb begin
        req           = '0;
        req[SRC_EXT]  = ext_halt_i;
        req[SRC_GRP]  = grp_halt_i;
        req[SRC_HBIT] = halt_bit_i;
        req[SRC_BKPT] = bkpt_trap_i & bkpt_route;
    end

    always_comb begin
        cause_o = CAUSE_NONE;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (req[i]) cause_o = src_cause(i);
        end
    end

    assign enter_o       = ~dbg_mode_i & (|req);
    assign bkpt_normal_o = ~dbg_mode_i & bkpt_trap_i & ~(|req);

endmodule

// File: rtl/dbg_seq.sv
module dbg_seq
    import dbg_pkg::*;
#(
    parameter int          PC_W      = 32,
    parameter int unsigned ROM_ENTRY = 32'h0000_0800
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            enter_i,
    input  logic            dret_i,
    input  logic [PC_W-1:0] cur_pc_i,
    input  priv_e           saved_priv_i,
    input  logic            step_bit_i,
    output logic            dbg_mode_o,
    output logic            redirect_o,
    output logic [PC_W-1:0] next_pc_o,
    output priv_e           next_priv_o,
    output logic [PC_W-1:0] dpc_o,
    output logic            step_arm_o
);

    localparam logic [PC_W-1:0] ENTRY_PC = PC_W'(ROM_ENTRY);

    logic do_ret;
    assign do_ret = dret_i & dbg_mode_o;

    always_ff @(posedge clk) begin
        if (rst) begin
            dbg_mode_o  <= 1'b0;
            redirect_o  <= 1'b0;
            next_pc_o   <= '0;
            next_priv_o <= PRIV_M;
            dpc_o       <= '0;
            step_arm_o  <= 1'b0;
        end else begin
            redirect_o <= 1'b0;
            if (enter_i) begin
                dbg_mode_o  <= 1'b1;
                redirect_o  <= 1'b1;
                next_pc_o   <= ENTRY_PC;
                next_priv_o <= PRIV_M;
                dpc_o       <= cur_pc_i;
                step_arm_o  <= 1'b0;
            end else if (do_ret) begin
                dbg_mode_o  <= 1'b0;
                redirect_o  <= 1'b1;
                next_pc_o   <= dpc_o;
                next_priv_o <= saved_priv_i;
                step_arm_o  <= step_bit_i;
            end
        end
    end

endmodule

// File: rtl/dbg_ctl.sv
module dbg_ctl
    import dbg_pkg::*;
#(
    parameter int          PC_W      = 32,
    parameter int unsigned ROM_ENTRY = 32'h0000_0800
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            halt_on_reset_i,
    input  logic [PC_W-1:0] cur_pc_i,
    input  logic [1:0]      cur_priv_i,
    input  logic            ext_halt_i,
    input  logic            grp_halt_i,
    input  logic            bkpt_trap_i,
    input  logic            csr_rd_i,
    input  logic            csr_wr_i,
    input  logic [31:0]     csr_wdata_i,
    input  logic            dret_i,
    output logic            dbg_mode_o,
    output logic            redirect_o,
    output logic [PC_W-1:0] next_pc_o,
    output logic [1:0]      next_priv_o,
    output logic [PC_W-1:0] dpc_o,
    output logic            step_arm_o,
    output logic            illegal_o,
    output logic            bkpt_normal_o,
    output logic [31:0]     csr_rdata_o
);

    dstat_t stat;
    logic   enter;
    cause_e cause;
    priv_e  npriv;

    dbg_cause_arb u_arb (
        .dbg_mode_i    (dbg_mode_o),
        .ext_halt_i    (ext_halt_i),
        .grp_halt_i    (grp_halt_i),
        .halt_bit_i    (stat.halt),
        .bkpt_trap_i   (bkpt_trap_i),
        .cur_priv_i    (priv_e'(cur_priv_i)),
        .eb_m_i        (stat.eb_m),
        .eb_s_i        (stat.eb_s),
        .eb_u_i        (stat.eb_u),
        .enter_o       (enter),
        .cause_o       (cause),
        .bkpt_normal_o (bkpt_normal_o)
    );

    dbg_stat_reg u_stat (
        .clk             (clk),
        .rst             (rst),
        .halt_on_reset_i (halt_on_reset_i),
        .wr_en_i         (csr_wr_i & dbg_mode_o),
        .wdata_i         (csr_wdata_i),
        .enter_i         (enter),
        .enter_cause_i   (cause),
        .enter_priv_i    (priv_e'(cur_priv_i)),
        .stat_o          (stat)
    );

    dbg_seq #(
        .PC_W      (PC_W),
        .ROM_ENTRY (ROM_ENTRY)
    ) u_seq (
        .clk          (clk),
        .rst          (rst),
        .enter_i      (enter),
        .dret_i       (dret_i),
        .cur_pc_i     (cur_pc_i),
        .saved_priv_i (stat.prv),
        .step_bit_i   (stat.step),
        .dbg_mode_o   (dbg_mode_o),
        .redirect_o   (redirect_o),
        .next_pc_o    (next_pc_o),
        .next_priv_o  (npriv),
        .dpc_o        (dpc_o),
        .step_arm_o   (step_arm_o)
    );

    assign next_priv_o = npriv;
    assign illegal_o   = (csr_rd_i | csr_wr_i | dret_i) & ~dbg_mode_o;
    assign csr_rdata_o = pack_stat(stat);

endmodule

// File: rtl/dbg_ctl_chk.sv
module dbg_ctl_chk #(
    parameter int          PC_W      = 32,
    parameter int unsigned ROM_ENTRY = 32'h0000_0800
) (
    input logic            clk,
    input logic            rst,
    input logic [PC_W-1:0] cur_pc_i,
    input logic [1:0]      cur_priv_i,
    input logic            csr_wr_i,
    input logic            dret_i,
    input logic            dbg_mode_o,
    input logic            redirect_o,
    input logic [PC_W-1:0] next_pc_o,
    input logic [1:0]      next_priv_o,
    input logic [PC_W-1:0] dpc_o,
    input logic            step_arm_o,
    input logic            bkpt_normal_o,
    input logic [31:0]     csr_rdata_o
);

    a_r4_entry_redirect: assert property (@(posedge clk) disable iff (rst)
        $rose(dbg_mode_o) |-> redirect_o && next_pc_o == PC_W'(ROM_ENTRY) && next_priv_o == 2'd3);

    a_r4_entry_capture: assert property (@(posedge clk) disable iff (rst)
        $rose(dbg_mode_o) |-> dpc_o == $past(cur_pc_i) && csr_rdata_o[1:0] == $past(cur_priv_i));

    a_r7_return_target: assert property (@(posedge clk) disable iff (rst)
        $fell(dbg_mode_o) |-> redirect_o && next_pc_o == $past(dpc_o));

    a_r1_no_write_outside: assert property (@(posedge clk) disable iff (rst)
        csr_wr_i && !dbg_mode_o |=> csr_rdata_o[15:12] == $past(csr_rdata_o[15:12])
                                    && csr_rdata_o[3:2] == $past(csr_rdata_o[3:2]));

    a_r8_dret_ignored: assert property (@(posedge clk) disable iff (rst)
        dret_i && !dbg_mode_o |=> !redirect_o || dbg_mode_o);

    a_r10_step_clear: assert property (@(posedge clk) disable iff (rst)
        $rose(dbg_mode_o) |-> !step_arm_o);

    a_r5_bkpt_no_entry: assert property (@(posedge clk) disable iff (rst)
        bkpt_normal_o |=> !dbg_mode_o);

endmodule

bind dbg_ctl dbg_ctl_chk #(
    .PC_W      (PC_W),
    .ROM_ENTRY (ROM_ENTRY)
) u_chk (
    .clk           (clk),
    .rst           (rst),
    .cur_pc_i      (cur_pc_i),
    .cur_priv_i    (cur_priv_i),
    .csr_wr_i      (csr_wr_i),
    .dret_i        (dret_i),
    .dbg_mode_o    (dbg_mode_o),
    .redirect_o    (redirect_o),
    .next_pc_o     (next_pc_o),
    .next_priv_o   (next_priv_o),
    .dpc_o         (dpc_o),
    .step_arm_o    (step_arm_o),
    .bkpt_normal_o (bkpt_normal_o),
    .csr_rdata_o   (csr_rdata_o)
);

// File: tb/dbg_ctl_test.sv
module dbg_ctl_test;

    localparam int          PC_W = 32;
    localparam logic [31:0] ROM  = 32'h0000_0800;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        hor = 1'b1;
    logic [31:0] pc = 32'h100;
    logic [1:0]  priv = 2'd0;
    logic        ext = 1'b0, grp = 1'b0, bkpt = 1'b0;
    logic        crd = 1'b0, cwr = 1'b0, dret = 1'b0;
    logic [31:0] wd = '0;

    logic        mode, redir, sarm, illg, bnorm;
    logic [31:0] npc, dpc, rdata;
    logic [1:0]  npriv;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    // bench model of the status word
    logic       m_ebm = 0, m_ebh = 0, m_ebs = 0, m_ebu = 0, m_halt = 0, m_step = 0;
    logic [1:0] m_prv = 0;
    logic [2:0] m_cause = 0;
    logic       m_mode = 0, m_arm = 0;
    logic [31:0] m_dpc = 0;

    always #4 clk = ~clk;

    dbg_ctl #(.PC_W(PC_W), .ROM_ENTRY(ROM)) uut (
        .clk(clk), .rst(rst), .halt_on_reset_i(hor), .cur_pc_i(pc), .cur_priv_i(priv),
        .ext_halt_i(ext), .grp_halt_i(grp), .bkpt_trap_i(bkpt), .csr_rd_i(crd),
        .csr_wr_i(cwr), .csr_wdata_i(wd), .dret_i(dret), .dbg_mode_o(mode),
        .redirect_o(redir), .next_pc_o(npc), .next_priv_o(npriv), .dpc_o(dpc),
        .step_arm_o(sarm), .illegal_o(illg), .bkpt_normal_o(bnorm), .csr_rdata_o(rdata)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] expw();
        return {4'd1, 12'd0, m_ebm, m_ebh, m_ebs, m_ebu, 3'b000, m_cause,
                2'b00, m_halt, m_step, m_prv};
    endfunction

    // junk in version, cause and stop bits must not stick (R3)
    function automatic logic [31:0] mkw(input logic [3:0] eb, input logic h,
                                        input logic s, input logic [1:0] p);
        return {4'hF, 12'hABC, eb, 3'b111, 3'b111, 2'b11, h, s, p};
    endfunction

    task automatic rd(input string tag);
        crd = 1'b1;
        #1;
        chk(tag, rdata, expw());
        chk({tag, " illegal"}, {31'd0, illg}, {31'd0, ~m_mode});
        crd = 1'b0;
        #1;
    endtask

    task automatic wr(input logic [31:0] w);
        cwr = 1'b1;
        wd  = w;
        #1;
        chk("R1 write illegal flag", {31'd0, illg}, {31'd0, ~m_mode});
        @(negedge clk);
        cwr = 1'b0;
        if (m_mode) begin
            {m_ebm, m_ebh, m_ebs, m_ebu} = w[15:12];
            m_halt = w[3];
            m_step = w[2];
            m_prv  = w[1:0];
        end
    endtask

    task automatic ret(input string tag);
        logic was;
        was  = m_mode;
        dret = 1'b1;
        #1;
        chk({tag, " dret illegal"}, {31'd0, illg}, {31'd0, ~was});
        @(negedge clk);
        dret = 1'b0;
        chk({tag, " redirect"}, {31'd0, redir}, {31'd0, was});
        if (was) begin
            m_mode = 0;
            m_arm  = m_step;
            chk({tag, " next_pc"}, npc, m_dpc);
            chk({tag, " next_priv"}, {30'd0, npriv}, {30'd0, m_prv});
        end
        chk({tag, " mode"}, {31'd0, mode}, {31'd0, m_mode});
        chk({tag, " step_arm"}, {31'd0, sarm}, {31'd0, m_arm});
    endtask

    task automatic model_enter(input logic [2:0] c);
        m_cause = c;
        m_prv   = priv;
        m_dpc   = pc;
        m_mode  = 1;
        m_arm   = 0;
    endtask

    task automatic entry_chk(input string tag);
        chk({tag, " mode"}, {31'd0, mode}, 32'd1);
        chk({tag, " redirect"}, {31'd0, redir}, 32'd1);
        chk({tag, " rom pc"}, npc, ROM);
        chk({tag, " priv M"}, {30'd0, npriv}, 32'd3);
        chk({tag, " dpc"}, dpc, m_dpc);
        chk({tag, " step_arm clear R10"}, {31'd0, sarm}, 32'd0);
        rd({tag, " word"});
    endtask

    task automatic halt_enter(input logic [31:0] p);
        ext = 1'b1;
        pc  = p;
        @(negedge clk);
        ext = 1'b0;
        model_enter(3'd3);
        entry_chk("R4 ext halt entry");
    endtask

    initial begin
        // R9 reset with halt-on-reset set
        repeat (3) @(negedge clk);
        chk("R9 reset mode", {31'd0, mode}, 32'd0);
        chk("R9 reset redirect", {31'd0, redir}, 32'd0);
        chk("R9 reset dpc", dpc, 32'd0);
        rst = 1'b0;
        hor = 1'b0;
        m_halt = 1;
        @(negedge clk);
        model_enter(3'd3);
        entry_chk("R9 halt after reset");

        // R3 / R2 writes
        wr(mkw(4'hF, 1'b0, 1'b1, 2'd3));
        rd("R3 write ones");
        wr(mkw(4'h0, 1'b0, 1'b0, 2'd0));
        rd("R3 write zeros");
        wr(mkw(4'hA, 1'b0, 1'b0, 2'd1));
        rd("R2 layout mixed");

        // R7 return with step set, R10 clear on next entry
        wr(mkw(4'h0, 1'b0, 1'b1, 2'd1));
        ret("R7 step return");
        chk("R7 step_arm set", {31'd0, sarm}, 32'd1);
        priv = 2'd1;
        halt_enter(32'h0000_1234);
        chk("R10 step_arm after entry", {31'd0, sarm}, 32'd0);

        // R8 and R1 outside debug mode
        wr(mkw(4'h0, 1'b0, 1'b0, 2'd0));
        ret("R7 plain return");
        priv = 2'd0;
        ret("R8 dret outside");
        wr(mkw(4'hF, 1'b1, 1'b1, 2'd3));
        crd = 1'b1;
        #1;
        chk("R1 read illegal", {31'd0, illg}, 32'd1);
        crd = 1'b0;
        chk("R1 no entry from write", {31'd0, mode}, 32'd0);
        halt_enter(32'h0000_2000);
        rd("R1 word unchanged");

        // R6 priority sweep over ext, grp, halt bit, routed breakpoint
        for (int mask = 1; mask < 16; mask++) begin
            logic [2:0] ec;
            priv = 2'd3;
            wr(mkw(4'h8, mask[2], 1'b0, 2'd3));
            ret("R6 prep return");
            ext  = mask[0];
            grp  = mask[1];
            bkpt = mask[3];
            pc   = 32'h3000 + mask;
            #1;
            chk("R6 no normal trap", {31'd0, bnorm}, 32'd0);
            @(negedge clk);
            ext = 0; grp = 0; bkpt = 0;
            ec = mask[0] ? 3'd3 : mask[1] ? 3'd6 : mask[2] ? 3'd3 : 3'd1;
            model_enter(ec);
            entry_chk("R6 priority");
        end

        // R5 breakpoint routing sweep: privilege x ebreak bits
        for (int p = 0; p < 4; p++) begin
            for (int e = 0; e < 16; e++) begin
                logic en;
                logic [3:0] eb;
                eb = e[3:0];
                en = (p == 3 && eb[3]) || (p == 1 && eb[1]) || (p == 0 && eb[0]);
                priv = p[1:0];
                wr(mkw(eb, 1'b0, 1'b0, p[1:0]));
                ret("R5 prep return");
                bkpt = 1'b1;
                pc   = 32'h4000 + 32'(p * 16 + e);
                #1;
                chk("R5 normal trap flag", {31'd0, bnorm}, {31'd0, ~en});
                @(negedge clk);
                bkpt = 1'b0;
                if (en) begin
                    model_enter(3'd1);
                    entry_chk("R5 breakpoint entry");
                end else begin
                    chk("R5 no entry", {31'd0, mode}, 32'd0);
                    halt_enter(32'h5000);
                end
            end
        end

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog act=hung exp=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule